// File: doc/BRIEF.md
# Timed Receive Capture Controller

This block turns a strobed sample source into a stream of time-stamped entries, under the control of capture commands written over a simple settings bus. Each command gives a start mode, a start time and a line count. Immediate commands start as soon as they leave the command queue. Timed commands wait until a 64-bit time input equals their start time. A chain flag marks that the next queued command continues the same burst without a gap.

While a capture is active the block raises `runOut` and takes one sample on every cycle where `strobe` is high. Each sample becomes one output entry holding the current time, five flag bits and the sample word, offered on a valid/ready port. Three faults are reported downstream as error entries that carry no sample data:
- a timed start that is already in the past;
- a chained command that ends with nothing queued behind it;
- a sample that arrives while the output register is still full.

After an error, nothing further is taken from the queue until the error entry has been accepted.

Top module: `rx_timed_capture`

## Requirements
- R1: A command is built from three settings writes. Address base+0 holds the mode word: bit 31 is immediate, bit 30 is chain, bit 29 is ignored, and bits 28:0 are the line count. Address base+1 holds the upper 32 bits of the start time. A write to base+2 holds the lower 32 bits and pushes the command into a four-entry queue. Writes to any other address push nothing.
- R2: An immediate command ignores its start time and starts capture directly from idle.
- R3: During a capture of N lines, exactly N entries are produced, one for each cycle with `strobe` high while `runOut` is high. Each entry carries `sampleIn` and `nowTime` from that same cycle. A held entry stays stable until it is accepted.
- R4: The flags field is outData[SW+4:SW]. Bit 4 marks the start of a burst, bit 3 marks the end of a burst, and bits 2:0 hold the error code. Error codes are 0 none, 1 late, 2 broken chain, 3 overrun. In a clean burst only the first entry has bit 4 set, only the last has bit 3 set, and the error code is 0. The time field is outData[SW+68:SW+5].
- R5: A timed command raises `runOut` at the first clock edge where `nowTime` equals its start time. With a continuous strobe, the first entry is therefore stamped start+1. `runOut` never rises earlier.
- R6: A timed command whose start time is already below `nowTime` produces no capture. It produces a single entry with flags {0,1,late} and a zero sample.
- R7: When a chained command takes its last sample and another command with a nonzero line count is queued, capture continues without a gap. The continuation ignores the new command's start mode. The whole chain is one burst: one start mark, one end mark.
- R8: A chained command followed by a zero-line command ends the burst cleanly. The last sample carries the end mark and no error entry follows.
- R9: A chained command that ends with an empty queue marks its last sample with the end mark. It is then followed by an entry with flags {0,1,broken chain} and a zero sample.
- R10: A strobe during capture while the output register holds an entry that is not being accepted drops `runOut`. That strobe's sample is discarded, and an entry with flags {0,1,overrun} follows the held entry.
- R11: After any error, a queued command does not start until the error entry has been accepted downstream.
- R12: A zero-line command taken from idle is discarded without running or producing entries.
- R13: Reset or `clear` empties the queue, discards any held output entry and returns the block to idle. Commands written afterwards behave normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Synchronous flush of queue and state |
| cfgStb | input | 1 | Settings write strobe |
| cfgAddr | input | 8 | Settings write address |
| cfgData | input | 32 | Settings write data |
| nowTime | input | 64 | Current time |
| strobe | input | 1 | Sample-valid strobe from the sample source |
| sampleIn | input | SAMPLE_W | Sample word |
| runOut | output | 1 | High while capturing |
| outData | output | 69+SAMPLE_W | Entry: {time, flags, sample} |
| outValid | output | 1 | Entry valid |
| outReady | input | 1 | Downstream accepts entry |

## Verification
Immediate commands are swept over line counts 1 to 5 at strobe spacings of 1, 2 and 3 cycles. The sweep separates per-strobe sampling from per-cycle sampling, and separates off-by-one line counting from correct counting through the spacing between time stamps. Timed commands are tried once in the future and once in the past, which distinguishes an exact-match start from late rejection. Chain cases pair a chained command with a nonzero follower, with a zero-line follower and with no follower, so the continuation, the clean end and the broken-chain report are each exercised. Holding `outReady` low forces an overrun while a second command is queued. This shows that the error entry comes before the queued command starts. Separate cases cover `clear` with queued work, a zero-line command and writes to an unused address.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int LINES_W = 29;
  localparam int FLAGS_W = 5;

  typedef enum logic [2:0] {
    ERR_NONE    = 3'd0,
    ERR_LATE    = 3'd1,
    ERR_BROKEN  = 3'd2,
    ERR_OVERRUN = 3'd3
  } errCode_t;

  typedef struct packed {
    logic               imm;
    logic               chain;
    logic [LINES_W-1:0] lines;
    logic [63:0]        start;
  } rxCmd_t;

  typedef struct packed {
    logic     loadSample;
    logic     loadError;
    logic     sob;
    logic     eob;
    errCode_t err;
  } dpCtrl_t;
endpackage

// File: rtl/rxs_cmd_queue.sv
module rxs_cmd_queue
  import rxs_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int BASE  = 0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  logic        cfgStb,
  input  logic [7:0]  cfgAddr,
  input  logic [31:0] cfgData,
  input  logic        pop,
  output rxCmd_t      head,
  output logic        headValid
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [7:0] ADDR_MODE = 8'(BASE);
  localparam logic [7:0] ADDR_HI   = 8'(BASE + 1);
  localparam logic [7:0] ADDR_LO   = 8'(BASE + 2);

  logic [31:0] modeWord;
  logic [31:0] startHi;
  rxCmd_t      slots [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic doPush, doPop;

  assign doPush    = cfgStb && (cfgAddr == ADDR_LO) && (count != CNT_W'(DEPTH));
  assign doPop     = pop && (count != '0);
  assign headValid = (count != '0);
  assign head      = slots[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      modeWord <= '0;
      startHi  <= '0;
    end else if (cfgStb) begin
      if (cfgAddr == ADDR_MODE) modeWord <= cfgData;
      if (cfgAddr == ADDR_HI)   startHi  <= cfgData;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush) begin
      slots[wrPtr] <= '{imm:   modeWord[31],
                        chain: modeWord[30],
                        lines: modeWord[LINES_W-1:0],
                        start: {startHi, cfgData}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + CNT_W'(1);
      else if (doPop && !doPush) count <= count - CNT_W'(1);
    end
  end

  // R1: queue occupancy never exceeds its depth
  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/rxs_control.sv
module rxs_control
  import rxs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        clear,
  input  rxCmd_t      head,
  input  logic        headValid,
  input  logic [63:0] nowTime,
  input  logic        strobe,
  input  logic        canLoad,
  input  logic        outReady,
  output logic        pop,
  output logic        runOut,
  output dpCtrl_t     ctrl
);
  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_RUN, S_ERR, S_ERRWAIT} state_t;

  state_t             state, nState;
  logic [LINES_W-1:0] remain, nRemain;
  logic               chainCur, nChain;
  logic [63:0]        startT, nStart;
  logic               firstPend, nFirst;
  errCode_t           errReg, nErr;

  assign runOut = (state == S_RUN);

  always_comb begin
    nState  = state;
    nRemain = remain;
    nChain  = chainCur;
    nStart  = startT;
    nFirst  = firstPend;
    nErr    = errReg;
    pop     = 1'b0;
    ctrl    = '0;
    unique case (state)
      S_IDLE: begin
        if (headValid) begin
          pop = 1'b1;
          if (head.lines != '0) begin
            nRemain = head.lines;
            nChain  = head.chain;
            nStart  = head.start;
            nFirst  = 1'b1;
            nState  = head.imm ? S_RUN : S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (nowTime == startT) begin
          nState = S_RUN;
        end else if (nowTime > startT) begin
          nErr   = ERR_LATE;
          nState = S_ERR;
        end
      end
      S_RUN: begin
        if (strobe) begin
          if (!canLoad) begin
            nErr   = ERR_OVERRUN;
            nState = S_ERR;
          end else begin
            ctrl.loadSample = 1'b1;
            ctrl.sob        = firstPend;
            nFirst          = 1'b0;
            if (remain == LINES_W'(1)) begin
              if (chainCur && headValid) begin
                pop = 1'b1;
                if (head.lines == '0) begin
                  ctrl.eob = 1'b1;
                  nState   = S_IDLE;
                end else begin
                  nRemain = head.lines;
                  nChain  = head.chain;
                end
              end else begin
                ctrl.eob = 1'b1;
                if (chainCur) begin
                  nErr   = ERR_BROKEN;
                  nState = S_ERR;
                end else begin
                  nState = S_IDLE;
                end
              end
            end else begin
              nRemain = remain - LINES_W'(1);
            end
          end
        end
      end
      S_ERR: begin
        if (canLoad) begin
          ctrl.loadError = 1'b1;
          ctrl.eob       = 1'b1;
          ctrl.err       = errReg;
          nState         = S_ERRWAIT;
        end
      end
      S_ERRWAIT: begin
        if (outReady) nState = S_IDLE;
      end
      default: nState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      state     <= S_IDLE;
      remain    <= '0;
      chainCur  <= 1'b0;
      startT    <= '0;
      firstPend <= 1'b0;
      errReg    <= ERR_NONE;
    end else begin
      state     <= nState;
      remain    <= nRemain;
      chainCur  <= nChain;
      startT    <= nStart;
      firstPend <= nFirst;
      errReg    <= nErr;
    end
  end

  // R5: while waiting for a future start time, run stays low next cycle
  assert_wait_no_early_R5: assert property (@(posedge clk) disable iff (rst || clear)
    (state == S_WAIT && nowTime < startT) |=> !runOut);

  // R11: the queue is not consumed while an error report is pending
  assert_err_blocks_pop_R11: assert property (@(posedge clk) disable iff (rst || clear)
    (state == S_ERR || state == S_ERRWAIT) |-> !pop);
endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int SAMPLE_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clear,
  input  dpCtrl_t                      ctrl,
  input  logic [63:0]                  nowTime,
  input  logic [SAMPLE_W-1:0]          sampleIn,
  input  logic                         outReady,
  output logic [64+FLAGS_W+SAMPLE_W-1:0] outData,
  output logic                         outValid,
  output logic                         canLoad
);
  logic [FLAGS_W-1:0]  flagBits;
  logic [SAMPLE_W-1:0] payload;

  assign canLoad  = !outValid || outReady;
  assign flagBits = {ctrl.sob, ctrl.eob, ctrl.err};
  assign payload  = ctrl.loadError ? '0 : sampleIn;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else if (ctrl.loadSample || ctrl.loadError) begin
      outValid <= 1'b1;
      outData  <= {nowTime, flagBits, payload};
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R3: a held entry is not replaced or withdrawn before acceptance
  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (rst || clear)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  // R3: the control only loads the register when it is free
  assert_load_when_free_R3: assert property (@(posedge clk) disable iff (rst || clear)
    (ctrl.loadSample || ctrl.loadError) |-> (!outValid || outReady));
endmodule

// File: rtl/rx_timed_capture.sv
module rx_timed_capture
  import rxs_pkg::*;
#(
  parameter int SAMPLE_W    = 32,
  parameter int QUEUE_DEPTH = 4,
  parameter int CFG_BASE    = 0
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          clear,
  input  logic                          cfgStb,
  input  logic [7:0]                    cfgAddr,
  input  logic [31:0]                   cfgData,
  input  logic [63:0]                   nowTime,
  input  logic                          strobe,
  input  logic [SAMPLE_W-1:0]           sampleIn,
  output logic                          runOut,
  output logic [64+FLAGS_W+SAMPLE_W-1:0] outData,
  output logic                          outValid,
  input  logic                          outReady
);
  localparam int ERR_LSB = SAMPLE_W;

  rxCmd_t  head;
  logic    headValid;
  logic    pop;
  logic    canLoad;
  dpCtrl_t ctrl;

  rxs_cmd_queue #(.DEPTH(QUEUE_DEPTH), .BASE(CFG_BASE)) u_queue (
    .clk(clk), .rst(rst), .clear(clear),
    .cfgStb(cfgStb), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pop(pop), .head(head), .headValid(headValid)
  );

  rxs_control u_control (
    .clk(clk), .rst(rst), .clear(clear),
    .head(head), .headValid(headValid), .nowTime(nowTime),
    .strobe(strobe), .canLoad(canLoad), .outReady(outReady),
    .pop(pop), .runOut(runOut), .ctrl(ctrl)
  );

  rxs_datapath #(.SAMPLE_W(SAMPLE_W)) u_datapath (
    .clk(clk), .rst(rst), .clear(clear), .ctrl(ctrl),
    .nowTime(nowTime), .sampleIn(sampleIn), .outReady(outReady),
    .outData(outData), .outValid(outValid), .canLoad(canLoad)
  );

  // R9: a newly presented error entry is never offered while capturing
  assert_err_not_running_R9: assert property (@(posedge clk) disable iff (rst || clear)
    ($rose(outValid) && outData[ERR_LSB+2:ERR_LSB] != 3'd0) |-> !runOut);
endmodule

// File: tb/test_rx_timed_capture.sv
module test_rx_timed_capture;
  localparam int SW = 32;
  localparam int EW = 64 + 5 + SW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clear = 1'b0;
  logic cfgStb = 1'b0;
  logic [7:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic [63:0] nowTime = 64'd100;
  logic strobe = 1'b0;
  logic [SW-1:0] sampleIn = '0;
  logic runOut;
  logic [EW-1:0] outData;
  logic outValid;
  logic outReady = 1'b1;

  rx_timed_capture #(.SAMPLE_W(SW)) i_rx_timed_capture (
    .clk(clk), .rst(rst), .clear(clear),
    .cfgStb(cfgStb), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .nowTime(nowTime), .strobe(strobe), .sampleIn(sampleIn),
    .runOut(runOut), .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  always #10 clk = ~clk;

  int total = 0;
  int failed = 0;
  bit finished = 0;
  int strobePeriod = 1;
  int phase = 0;

  logic [63:0] capTime [64];
  logic [4:0]  capFlags [64];
  logic [SW-1:0] capSample [64];
  int capCount = 0;
  bit runSeen = 0;
  logic [63:0] runRise = '0;

  function automatic logic [SW-1:0] sampleOf(input logic [63:0] t);
    return t[31:0] * 32'd3 + 32'd11;
  endfunction

  // time, sample and strobe sources, driven away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      nowTime  = nowTime + 64'd1;
      sampleIn = sampleOf(nowTime);
      phase    = (phase + 1 >= strobePeriod) ? 0 : phase + 1;
      strobe   = (phase == 0);
    end
  end

  // monitor just before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #8;
      if (!rst && outValid && outReady && capCount < 64) begin
        capTime[capCount]   = outData[EW-1:EW-64];
        capFlags[capCount]  = outData[SW+4:SW];
        capSample[capCount] = outData[SW-1:0];
        capCount++;
      end
      if (!rst && runOut && !runSeen) begin
        runSeen = 1;
        runRise = nowTime;
      end
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cfgWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfgStb = 1'b1; cfgAddr = a; cfgData = d;
    @(negedge clk);
    cfgStb = 1'b0;
  endtask

  task automatic writeCmd(input bit imm, input bit chain, input int lines, input logic [63:0] st);
    cfgWrite(8'd0, {imm, chain, 1'b0, 29'(lines)});
    cfgWrite(8'd1, st[63:32]);
    cfgWrite(8'd2, st[31:0]);
  endtask

  task automatic resetCap();
    capCount = 0;
    runSeen  = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", total, failed);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    failed++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish();
  end

  initial begin
    cycles(5);
    check("R13 reset outValid", 64'(outValid), 64'd0);
    check("R13 reset runOut", 64'(runOut), 64'd0);
    rst = 1'b0;
    cycles(3);

    // sweep: line counts and strobe spacings, immediate start with far start time
    for (int p = 1; p <= 3; p++) begin
      for (int n = 1; n <= 5; n++) begin
        strobePeriod = p;
        resetCap();
        writeCmd(1'b1, 1'b0, n, 64'hFFFF_0000_0000_0000);
        cycles(20 + 3 * n * p);
        check("R2 immediate start ignores time", 64'(runSeen), 64'd1);
        check("R3 entry count", 64'(capCount), 64'(n));
        for (int i = 0; i < n && i < capCount; i++) begin
          check("R3 sample matches time", 64'(capSample[i]), 64'(sampleOf(capTime[i])));
          check("R4 start mark", 64'(capFlags[i][4]), 64'(i == 0));
          check("R4 end mark", 64'(capFlags[i][3]), 64'(i == n - 1));
          check("R4 error code none", 64'(capFlags[i][2:0]), 64'd0);
          if (i > 0) check("R3 one sample per strobe", capTime[i] - capTime[i-1], 64'(p));
        end
      end
    end

    // timed start in the future
    strobePeriod = 1;
    begin
      logic [63:0] st;
      resetCap();
      st = nowTime + 64'd30;
      writeCmd(1'b0, 1'b0, 3, st);
      cycles(60);
      check("R5 run rises at start", runRise, st + 64'd1);
      check("R5 entry count", 64'(capCount), 64'd3);
      check("R5 first stamp", capTime[0], st + 64'd1);
    end

    // late timed start
    resetCap();
    writeCmd(1'b0, 1'b0, 4, 64'd5);
    cycles(30);
    check("R6 no run when late", 64'(runSeen), 64'd0);
    check("R6 single entry", 64'(capCount), 64'd1);
    check("R6 late flags", 64'(capFlags[0]), 64'(5'b01001));
    check("R6 zero sample", 64'(capSample[0]), 64'd0);

    // chain continuation
    strobePeriod = 4;
    resetCap();
    writeCmd(1'b1, 1'b1, 3, 64'd0);
    writeCmd(1'b1, 1'b0, 2, 64'd0);
    cycles(60);
    check("R7 chained count", 64'(capCount), 64'd5);
    for (int i = 0; i < 5; i++) begin
      check("R7 chained flags", 64'(capFlags[i]), (i == 0) ? 64'(5'b10000) : (i == 4) ? 64'(5'b01000) : 64'd0);
      if (i > 0) check("R7 no gap", capTime[i] - capTime[i-1], 64'd4);
    end

    // chain closed by a zero-line command
    resetCap();
    writeCmd(1'b1, 1'b1, 2, 64'd0);
    writeCmd(1'b1, 1'b0, 0, 64'd0);
    cycles(50);
    check("R8 clean end count", 64'(capCount), 64'd2);
    check("R8 last flags", 64'(capFlags[1]), 64'(5'b01000));

    // broken chain
    strobePeriod = 1;
    resetCap();
    writeCmd(1'b1, 1'b1, 2, 64'd0);
    cycles(30);
    check("R9 broken count", 64'(capCount), 64'd3);
    check("R9 last sample flags", 64'(capFlags[1]), 64'(5'b01000));
    check("R9 error flags", 64'(capFlags[2]), 64'(5'b01010));
    check("R9 error sample", 64'(capSample[2]), 64'd0);

    // overrun with a command queued behind it
    strobePeriod = 2;
    resetCap();
    outReady = 1'b0;
    writeCmd(1'b1, 1'b0, 5, 64'd0);
    cycles(30);
    check("R10 run dropped", 64'(runOut), 64'd0);
    runSeen = 0;
    writeCmd(1'b1, 1'b0, 2, 64'd0);
    cycles(30);
    check("R11 queued waits for report", 64'(runSeen), 64'd0);
    outReady = 1'b1;
    cycles(40);
    check("R10 entry count", 64'(capCount), 64'd4);
    check("R10 held sample flags", 64'(capFlags[0]), 64'(5'b10000));
    check("R10 overrun flags", 64'(capFlags[1]), 64'(5'b01011));
    check("R11 next burst start", 64'(capFlags[2]), 64'(5'b10000));
    check("R11 next burst end", 64'(capFlags[3]), 64'(5'b01000));

    // zero-line command alone
    strobePeriod = 1;
    resetCap();
    writeCmd(1'b1, 1'b0, 0, 64'd0);
    cycles(20);
    check("R12 no run", 64'(runSeen), 64'd0);
    check("R12 no entries", 64'(capCount), 64'd0);

    // clear with pending work
    resetCap();
    writeCmd(1'b0, 1'b0, 3, nowTime + 64'd1000);
    writeCmd(1'b1, 1'b0, 3, 64'd0);
    @(negedge clk); clear = 1'b1;
    @(negedge clk); clear = 1'b0;
    cycles(50);
    check("R13 clear stops work", 64'(capCount), 64'd0);
    check("R13 clear no run", 64'(runSeen), 64'd0);
    writeCmd(1'b1, 1'b0, 2, 64'd0);
    cycles(20);
    check("R13 after clear count", 64'(capCount), 64'd2);
    check("R13 after clear flags", 64'(capFlags[0]), 64'(5'b10000));

    // unused address does not push; reload bit ignored
    resetCap();
    cfgWrite(8'd0, {1'b1, 1'b0, 1'b1, 29'd2});
    cfgWrite(8'd1, 32'd0);
    cfgWrite(8'd3, 32'd0);
    cycles(20);
    check("R1 other address no push", 64'(capCount), 64'd0);
    cfgWrite(8'd2, 32'd0);
    cycles(20);
    check("R1 third write pushes", 64'(capCount), 64'd2);
    check("R1 end flags", 64'(capFlags[1]), 64'(5'b01000));

    finish();
  end
endmodule